// File: doc/BRIEF.md
# Partitioned Subword SIMD Adder

This block is one 64-bit adder/subtractor that can be split into narrow lanes. A lane-size input selects eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane computes the same operation on its own slice of the two operands, all in the same cycle. No carry or borrow passes from one lane into the next.

The operation select picks one of these:

- modulo (wrap-around) add or subtract;
- signed saturating add or subtract;
- unsigned saturating add or subtract;
- an unsigned rounding average.

In the saturating operations each lane clamps on its own, without regard to the other lanes. The block keeps no state other than its output register. It raises no flags and no exceptions.

A caller presents both operands, the lane size and the operation together with a valid strobe. One clock later, the packed result appears with a matching valid flag. When the strobe is low, the output register keeps its previous contents.

Top module: `simd_part_adder`

## Requirements
- R1: While `rst_n` is low, `res_out` is all zeros and `vld_out` is 0.
- R2: `lane_sz` picks the lane width: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = one 64-bit lane. Lane k occupies bits [k*W +: W]. No carry or borrow crosses a lane boundary.
- R3: `op_sel` 3'd0 gives a+b modulo 2^W per lane. `op_sel` 3'd1 gives a-b modulo 2^W per lane.
- R4: `op_sel` 3'd2 is a signed saturating add and 3'd4 is a signed saturating subtract. A lane whose true result is above the largest signed W-bit value gives 0 followed by W-1 ones. A lane whose true result is below the smallest signed value gives 1 followed by W-1 zeros.
- R5: `op_sel` 3'd3 is an unsigned saturating add. A lane whose sum exceeds 2^W-1 gives all ones.
- R6: `op_sel` 3'd5 is an unsigned saturating subtract. A lane where b > a gives zero.
- R7: `op_sel` 3'd6 gives floor((a+b+1)/2) per lane, treating both operands as unsigned. The intermediate sum keeps its full W+1 bits, so the result is exact even when a+b+1 overflows W bits.
- R8: `op_sel` 3'd7 behaves exactly as the wrap-around add.
- R9: `vld_out` equals `vld_in` delayed by one clock. The result of an operation accepted at one rising edge is on `res_out` from that edge until the next accepted operation.
- R10: While `vld_in` is low, `res_out` holds its value whatever `opa`, `opb`, `lane_sz` and `op_sel` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_in | input | 1 | Operands and controls are valid this cycle |
| lane_sz | input | 2 | Lane width select (R2 encoding) |
| op_sel | input | 3 | Operation select (R3 to R8 encoding) |
| opa | input | 64 | First operand, packed lanes |
| opb | input | 64 | Second operand, packed lanes |
| res_out | output | 64 | Registered packed result |
| vld_out | output | 1 | Result valid, one cycle after `vld_in` |

## Verification
The bench builds the block with its default parameters: a 64-bit datapath cut into 8-bit segments. At these values all four lane widths are reachable, including the single 64-bit lane. In that lane the rounding average needs the 65th sum bit, and a subtract borrow must ripple through all eight segments. Hand-picked vectors place carries exactly on each lane seam. A pseudo-random sweep crosses every lane size with every operation code, including the spare one.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   typedef enum logic [1:0] {
      LSZ_8  = 2'b00,
      LSZ_16 = 2'b01,
      LSZ_32 = 2'b10,
      LSZ_64 = 2'b11
   } lane_sz_e;

   typedef enum logic [2:0] {
      OP_ADD    = 3'd0,
      OP_SUB    = 3'd1,
      OP_ADD_SS = 3'd2,
      OP_ADD_US = 3'd3,
      OP_SUB_SS = 3'd4,
      OP_SUB_US = 3'd5,
      OP_AVG    = 3'd6,
      OP_SPARE  = 3'd7
   } op_e;

endpackage

// File: rtl/simd_lane_ctl.sv
// Derives the segment boundary masks for the selected lane width.
module simd_lane_ctl #(
   parameter int NSEG = 8
) (
   input  logic [1:0]      lane_sz,
   output logic [NSEG-1:0] lane_lo,
   output logic [NSEG-1:0] lane_hi
);

   always_comb begin
      int span;
      span = 32'd1 << lane_sz;
      for (int i = 0; i < NSEG; i++) begin
         lane_lo[i] = ((i % span) == 0);
         lane_hi[i] = ((i % span) == (span - 1));
      end
   end

endmodule

// File: rtl/simd_seg_fix.sv
// Final result selection for one segment: wrap, clamp or average.
module simd_seg_fix
   import simd_add_pkg::*;
#(
   parameter int SEG_W = 8
) (
   input  op_e              op,
   input  logic             is_top,
   input  logic [SEG_W-1:0] wrap_sum,
   input  logic [SEG_W-1:0] avg_val,
   input  logic             l_cout,
   input  logic             l_sovf,
   input  logic             l_asign,
   output logic [SEG_W-1:0] res
);

   logic [SEG_W-1:0] ones, smax, smin;

   always_comb begin
      ones = '1;
      smax = is_top ? {1'b0, {(SEG_W-1){1'b1}}} : ones;
      smin = is_top ? {1'b1, {(SEG_W-1){1'b0}}} : '0;
      case (op)
         OP_ADD_SS, OP_SUB_SS: res = l_sovf ? (l_asign ? smin : smax) : wrap_sum;
         OP_ADD_US:            res = l_cout ? ones : wrap_sum;
         OP_SUB_US:            res = l_cout ? wrap_sum : '0;
         OP_AVG:               res = avg_val;
         default:              res = wrap_sum;
      endcase
   end

endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
   import simd_add_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_in,
   input  logic [1:0]        lane_sz,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res_out,
   output logic              vld_out
);

   localparam int NSEG = DATA_W / SEG_W;

   generate
      if ((DATA_W % SEG_W) != 0 || (NSEG % 8) != 0 || SEG_W < 2) begin : g_bad_cfg
         $error("simd_part_adder: DATA_W must be 8*k*SEG_W with SEG_W >= 2");
      end
   endgenerate

   op_e              op;
   logic             is_sub, is_avg;
   logic [NSEG-1:0]  lane_lo, lane_hi;
   logic [SEG_W-1:0] seg_sum [NSEG];
   logic             seg_cout [NSEG];
   logic             seg_sovf [NSEG];
   logic [SEG_W-1:0] avg_seg [NSEG];
   logic             l_cout [NSEG];
   logic             l_sovf [NSEG];
   logic             l_asign [NSEG];
   logic [DATA_W-1:0] res_d;
   logic [DATA_W-1:0] res_q;
   logic              vld_q;

   assign op     = op_e'(op_sel);
   assign is_sub = (op == OP_SUB) || (op == OP_SUB_SS) || (op == OP_SUB_US);
   assign is_avg = (op == OP_AVG);

   simd_lane_ctl #(.NSEG(NSEG)) u_ctl (
      .lane_sz (lane_sz),
      .lane_lo (lane_lo),
      .lane_hi (lane_hi)
   );

   // Segmented carry chain: a lane's first segment takes the lane carry-in.
   always_comb begin
      logic [SEG_W:0]   acc;
      logic [SEG_W-1:0] a_s, bx;
      logic             carry, cin;
      carry = 1'b0;
      for (int i = 0; i < NSEG; i++) begin
         a_s  = opa[i*SEG_W +: SEG_W];
         bx   = is_sub ? ~opb[i*SEG_W +: SEG_W] : opb[i*SEG_W +: SEG_W];
         cin  = lane_lo[i] ? (is_sub | is_avg) : carry;
         acc  = {1'b0, a_s} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};
         seg_sum[i]  = acc[SEG_W-1:0];
         seg_cout[i] = acc[SEG_W];
         seg_sovf[i] = (a_s[SEG_W-1] == bx[SEG_W-1]) && (acc[SEG_W-1] != a_s[SEG_W-1]);
         carry = acc[SEG_W];
      end
   end

   // Broadcast the lane's top-segment flags and build the shifted average.
   always_comb begin
      int span_m1, t, nx;
      span_m1 = (32'd1 << lane_sz) - 1;
      for (int i = 0; i < NSEG; i++) begin
         t  = i | span_m1;
         nx = (i + 1 < NSEG) ? i + 1 : i;
         l_cout[i]  = seg_cout[t];
         l_sovf[i]  = seg_sovf[t];
         l_asign[i] = opa[t*SEG_W + SEG_W - 1];
         avg_seg[i] = {(lane_hi[i] ? seg_cout[i] : seg_sum[nx][0]),
                       seg_sum[i][SEG_W-1:1]};
      end
   end

   generate
      for (genvar g = 0; g < NSEG; g++) begin : g_seg
         simd_seg_fix #(.SEG_W(SEG_W)) u_fix (
            .op       (op),
            .is_top   (lane_hi[g]),
            .wrap_sum (seg_sum[g]),
            .avg_val  (avg_seg[g]),
            .l_cout   (l_cout[g]),
            .l_sovf   (l_sovf[g]),
            .l_asign  (l_asign[g]),
            .res      (res_d[g*SEG_W +: SEG_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= vld_in;
         if (vld_in) res_q <= res_d;
      end
   end

   assign res_out = res_q;
   assign vld_out = vld_q;

   // R9
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_in |=> vld_out);
   // R9
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_in |=> !vld_out);
   // R10
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_in |=> $stable(res_out));

   generate
      for (genvar g = 0; g < NSEG; g++) begin : g_lane_chk
         // R5
         usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_in && lane_sz == 2'b00 && op_sel == 3'd3)
            |=> res_out[g*SEG_W +: SEG_W] >= $past(opa[g*SEG_W +: SEG_W]));
         // R6
         usub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_in && lane_sz == 2'b00 && op_sel == 3'd5)
            |=> res_out[g*SEG_W +: SEG_W] <= $past(opa[g*SEG_W +: SEG_W]));
         // R7
         avg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_in && lane_sz == 2'b00 && op_sel == 3'd6)
            |=> ((res_out[g*SEG_W +: SEG_W] >= $past(opa[g*SEG_W +: SEG_W])) ||
                 (res_out[g*SEG_W +: SEG_W] >= $past(opb[g*SEG_W +: SEG_W]))) &&
                ((res_out[g*SEG_W +: SEG_W] <= $past(opa[g*SEG_W +: SEG_W])) ||
                 (res_out[g*SEG_W +: SEG_W] <= $past(opb[g*SEG_W +: SEG_W]))));
         // R4
         ssat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_in && lane_sz == 2'b00 && op_sel == 3'd2 &&
             !opa[g*SEG_W + SEG_W - 1] && !opb[g*SEG_W + SEG_W - 1])
            |=> !res_out[g*SEG_W + SEG_W - 1]);
      end
   endgenerate

endmodule

// File: tb/simd_part_adder_tb_top.sv
`timescale 1ns/1ps
module simd_part_adder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld_in = 1'b0;
   logic [1:0]  lane_sz = 2'b00;
   logic [2:0]  op_sel = 3'd0;
   logic [63:0] opa = '0, opb = '0;
   logic [63:0] res_out;
   logic        vld_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #2.5 clk = ~clk;

   simd_part_adder dut_i (
      .clk(clk), .rst_n(rst_n), .vld_in(vld_in), .lane_sz(lane_sz),
      .op_sel(op_sel), .opa(opa), .opb(opb), .res_out(res_out), .vld_out(vld_out)
   );

   function automatic logic [63:0] ref_model(logic [1:0] sz, logic [2:0] op,
                                             logic [63:0] a, logic [63:0] b);
      int w, n;
      logic [63:0] res, mask;
      logic [65:0] ua, ub, r, emask;
      logic signed [65:0] sa, sb, s, smax, smin;
      w = 8 << sz;
      n = 64 / w;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      emask = {2'b00, mask};
      res = '0;
      for (int l = 0; l < n; l++) begin
         ua = {2'b00, (a >> (l*w)) & mask};
         ub = {2'b00, (b >> (l*w)) & mask};
         sa = $signed(((ua >> (w-1)) & 66'd1) != 0 ? (ua | ~emask) : ua);
         sb = $signed(((ub >> (w-1)) & 66'd1) != 0 ? (ub | ~emask) : ub);
         smax = $signed(emask >> 1);
         smin = -smax - 66'sd1;
         case (op)
            3'd1: r = ua - ub;
            3'd2, 3'd4: begin
               s = (op == 3'd2) ? sa + sb : sa - sb;
               if (s > smax) s = smax;
               else if (s < smin) s = smin;
               r = s;
            end
            3'd3: begin r = ua + ub; if (r > emask) r = emask; end
            3'd5: r = (ua < ub) ? 66'd0 : ua - ub;
            3'd6: r = (ua + ub + 66'd1) >> 1;
            default: r = ua + ub;
         endcase
         res = res | ((r[63:0] & mask) << (l*w));
      end
      return res;
   endfunction

   function automatic logic [63:0] next_rng(logic [63:0] x);
      logic [63:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Drive one valid operation, sample result after the capturing edge.
   task automatic apply(string req, logic [1:0] sz, logic [2:0] op,
                        logic [63:0] a, logic [63:0] b, logic [63:0] exp);
      @(negedge clk);
      lane_sz = sz; op_sel = op; opa = a; opb = b; vld_in = 1'b1;
      @(negedge clk);
      vld_in = 1'b0;
      check({req, " vld_out"}, {63'd0, vld_out}, 64'd1);
      check(req, res_out, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 res", res_out, 64'd0);
      check("R1 vld", {63'd0, vld_out}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after", res_out, 64'd0);
   endtask

   task automatic t_wrap();
      apply("R2 8b seam add", 2'b00, 3'd0, 64'h01FF01FF01FF01FF, 64'h0101010101010101, 64'h0200020002000200);
      apply("R2 16b seam add", 2'b01, 3'd0, 64'h01FF01FF01FF01FF, 64'h0101010101010101, 64'h0300030003000300);
      apply("R2 32b add", 2'b10, 3'd0, 64'hFFFFFFFF00000001, 64'h0000000100000001, 64'h0000000000000002);
      apply("R3 8b sub", 2'b00, 3'd1, 64'd0, 64'h0101010101010101, 64'hFFFFFFFFFFFFFFFF);
      apply("R3 64b sub", 2'b11, 3'd1, 64'd0, 64'h0101010101010101, 64'hFEFEFEFEFEFEFEFF);
      apply("R3 16b sub", 2'b01, 3'd1, 64'h0000000100020003, 64'h0001000100010001, 64'hFFFF000000010002);
   endtask

   task automatic t_ssat();
      apply("R4 8b add", 2'b00, 3'd2, 64'h7F80_7F80_1010_0505, 64'h01FF_7F80_1010_FBFB, 64'h7F80_7F80_2020_0000);
      apply("R4 16b add", 2'b01, 3'd2, 64'h7FFF_8000_0001_1234, 64'h0001_FFFF_7FFF_0000, 64'h7FFF_8000_7FFF_1234);
      apply("R4 8b sub", 2'b00, 3'd4, 64'h8000_7F00_0000_0000, 64'h0100_FF00_0000_0000, 64'h8000_7F00_0000_0000);
      apply("R4 64b sub", 2'b11, 3'd4, 64'h8000000000000000, 64'd1, 64'h8000000000000000);
   endtask

   task automatic t_usat();
      apply("R5 8b", 2'b00, 3'd3, 64'hFF01_8080_0000_7F7F, 64'h0101_8080_0000_0101, 64'hFF02_FFFF_0000_8080);
      apply("R5 32b", 2'b10, 3'd3, 64'hFFFFFFF0_00000001, 64'h00000020_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFF);
      apply("R6 8b", 2'b00, 3'd5, 64'h0005_1000_0000_0010, 64'h0106_0100_0000_0020, 64'h0000_0F00_0000_0000);
      apply("R6 16b", 2'b01, 3'd5, 64'h0100_0005_FFFF_0000, 64'h0001_0006_0001_0001, 64'h00FF_0000_FFFE_0000);
   endtask

   task automatic t_avg();
      apply("R7 8b", 2'b00, 3'd6, 64'hFFFF_0001_0203_0000, 64'hFF00_0001_0100_0000, 64'hFF80_0001_0202_0000);
      apply("R7 64b", 2'b11, 3'd6, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF);
      apply("R7 16b", 2'b01, 3'd6, 64'hFFFF_0000_0001_0002, 64'h0000_0000_0000_0001, 64'h8000_0000_0001_0002);
   endtask

   task automatic t_spare();
      apply("R8 8b", 2'b00, 3'd7, 64'h01FF01FF01FF01FF, 64'h0101010101010101, 64'h0200020002000200);
      apply("R8 64b", 2'b11, 3'd7, 64'h00000000FFFFFFFF, 64'd1, 64'h0000000100000000);
   endtask

   task automatic t_hold();
      logic [63:0] kept;
      apply("R9 setup", 2'b00, 3'd0, 64'h1111111111111111, 64'h2222222222222222, 64'h3333333333333333);
      kept = res_out;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         opa = next_rng(opa ^ 64'hA5); opb = ~opb; op_sel = 3'(k); lane_sz = 2'(k);
         check("R10 hold", res_out, kept);
         check("R9 idle", {63'd0, vld_out}, 64'd0);
      end
   endtask

   task automatic t_b2b();
      @(negedge clk);
      lane_sz = 2'b00; op_sel = 3'd0; opa = 64'h0102030405060708; opb = 64'h0101010101010101; vld_in = 1'b1;
      @(negedge clk);
      check("R9 b2b first", res_out, 64'h0203040506070809);
      check("R9 b2b vld", {63'd0, vld_out}, 64'd1);
      lane_sz = 2'b11; op_sel = 3'd1; opa = 64'd10; opb = 64'd3;
      @(negedge clk);
      vld_in = 1'b0;
      check("R9 b2b second", res_out, 64'd7);
      @(negedge clk);
      check("R9 drop", {63'd0, vld_out}, 64'd0);
   endtask

   task automatic t_sweep();
      logic [63:0] a, b;
      for (int k = 0; k < 512; k++) begin
         rng = next_rng(rng); a = rng;
         rng = next_rng(rng); b = rng;
         if (k % 5 == 0) b = a ^ 64'h8080808080808080;
         apply("R2-sweep R3 R4 R5 R6 R7 R8", 2'(k % 4), 3'((k / 4) % 8), a, b,
               ref_model(2'(k % 4), 3'((k / 4) % 8), a, b));
      end
   endtask

   initial begin
      t_reset();
      t_wrap();
      t_ssat();
      t_usat();
      t_avg();
      t_spare();
      t_hold();
      t_b2b();
      t_sweep();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #500000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule